// File: doc/BRIEF.md
# Burst-of-Two Shared-Bus Pipelined SRAM

This block is a cycle-accurate, synthesizable model of a synchronous pipelined SRAM. Reads and writes share one data path, and every command moves a fixed pair of words. The block samples a command on each rising clock edge. A command is accepted only while the active-low select is low, and the direction input chooses between a read and a write. The memory array is kept small so that simulation stays fast.

Each clock cycle has two double-data-rate phases: the rising-clock phase, called beat A, and the falling-clock phase, called beat B. The model carries both phases as separate word lanes within one clock cycle. The first beat of a burst goes to the command address. The second beat goes to the same address with its least significant bit inverted, so the burst wraps inside the aligned pair.

Read data leaves through a two-stage pipeline. Write data arrives late, one clock after its command. An output enable and a pair of echo strobes mark exactly the phases that carry read data. Outside those phases the output words are held at zero, which stands for a released (high-impedance) bus.

Top module: `b2s_sram`

## Requirements
- R1: A command is taken at a rising clock edge only when `sel_n` is 0 at that edge. When `sel_n` is 1, the edge starts no read and no write.
- R2: An accepted command with `rd_wr` = 1 is a read; with `rd_wr` = 0 it is a write.
- R3: Beat A of a burst addresses `addr`. Beat B addresses `addr` with bit 0 inverted. Only bit 0 changes.
- R4: A read sampled at edge n presents beat A on `rq_a` and beat B on `rq_b` during the cycle after edge n+2. Reads on consecutive edges give consecutive cycles of data with no gap.
- R5: For a write sampled at edge n, `wd_a` and `wd_b` are captured at edge n+1. A read sampled at edge n+1 or later returns the new data.
- R6: Bit i of `lane_en_a` (beat A) or `lane_en_b` (beat B) enables writing bits 9i to 9i+8 of that beat's word. Lane 0 covers bits 0–8 and lane 3 covers bits 27–35. A lane whose bit is 0 keeps its old contents.
- R7: `rq_oe` is 1 only in the cycles that carry read beats. `rq_a` and `rq_b` are 0 whenever `rq_oe` is 0. After `sel_n` goes high, a read in flight still completes, and then the bus is released.
- R8: Values on `wd_a`, `wd_b` and the lane enables at an edge that follows no accepted write have no effect on memory.
- R9: `strobe_a` and `strobe_b` are 1 exactly in the cycles whose beat A and beat B carry read data.
- R10: After reset, no command is in flight, and `rq_oe`, both strobes and both output words are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low command select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Word address of beat A |
| wd_a | input | 36 | Late write data, rising-clock beat |
| wd_b | input | 36 | Late write data, falling-clock beat |
| lane_en_a | input | 4 | Active-high lane write enables for beat A |
| lane_en_b | input | 4 | Active-high lane write enables for beat B |
| rq_a | output | 36 | Read data, rising-clock beat |
| rq_b | output | 36 | Read data, falling-clock beat |
| rq_oe | output | 1 | Output enable; 0 means the bus is released |
| strobe_a | output | 1 | Echo strobe for a beat-A read word |
| strobe_b | output | 1 | Echo strobe for a beat-B read word |

## Verification
All words are first preloaded with distinct values. Reads at even and odd addresses then show whether the second beat wraps inside its pair or runs on to the next pair. Back-to-back reads separate a continuous pipeline from one that inserts bubbles. A read issued on the edge right after a write to the same address shows whether the late-write data is committed in time.

Partial lane masks on each beat, together with garbage on the data inputs during idle and deselected cycles, separate correct lane gating from writes that leak. A long seeded random mix of reads, writes and deselects, checked against a reference memory kept in the bench, covers how these cases interact.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Which bank (0 = even, 1 = odd) a beat lands in, given the burst base
  // address bit 0 and whether the beat is the falling-clock one.
  function automatic logic beat_bank(input logic base_lsb, input logic is_beat_b);
    return base_lsb ^ is_beat_b;
  endfunction

  // Low bit position of a byte lane.
  function automatic int lane_lo(input int lane, input int lane_w);
    return lane * lane_w;
  endfunction

endpackage

// File: rtl/b2s_cmd_decode.sv
module b2s_cmd_decode
  import b2s_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op,
  output logic [ADDR_W-1:0] op_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op      <= OP_NONE;
      op_addr <= '0;
    end else begin
      if (sel_n)      op <= OP_NONE;
      else if (rd_wr) op <= OP_READ;
      else            op <= OP_WRITE;
      op_addr <= addr;
    end
  end

  // R1: a deselected edge leaves no command in flight
  a_r1_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_n) |-> (op == OP_NONE));

  // R2: a read command comes only from a high direction input
  a_r2_read_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |-> $past(rd_wr));

endmodule

// File: rtl/b2s_write_steer.sv
module b2s_write_steer
  import b2s_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic                    wr_go,
  input  logic                    base_lsb,
  input  logic [DW-1:0]           wd_a,
  input  logic [DW-1:0]           wd_b,
  input  logic [LANES-1:0]        en_a,
  input  logic [LANES-1:0]        en_b,
  output logic [1:0]              bank_we,
  output logic [1:0][DW-1:0]      bank_wd,
  output logic [1:0][LANES-1:0]   bank_en
);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic takes_a;
    assign takes_a    = (beat_bank(base_lsb, 1'b0) == b[0]);
    assign bank_we[b] = wr_go;
    assign bank_wd[b] = takes_a ? wd_a : wd_b;
    assign bank_en[b] = takes_a ? en_a : en_b;
  end

endmodule

// File: rtl/b2s_bank.sv
module b2s_bank
  import b2s_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  wlane,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DW-1:0]     wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DW-1:0]     rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = lane_lo(l, LANE_W);
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_lane;

    always_ff @(posedge clk) begin
      if (we && wlane[l]) mem[widx] <= wdata[LO +: LANE_W];
      if (re)             rd_lane   <= mem[ridx];
    end

    assign rdata[LO +: LANE_W] = rd_lane;
  end

endmodule

// File: rtl/b2s_read_pipe.sv
module b2s_read_pipe
  import b2s_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_go,
  input  logic                base_lsb,
  input  logic [1:0][DW-1:0]  bank_rd,
  output logic [DW-1:0]       q_a,
  output logic [DW-1:0]       q_b,
  output logic                oe,
  output logic                strobe_a,
  output logic                strobe_b
);

  logic fetch_v;
  logic fetch_lsb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_v   <= 1'b0;
      fetch_lsb <= 1'b0;
    end else begin
      fetch_v   <= rd_go;
      fetch_lsb <= base_lsb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe       <= 1'b0;
      strobe_a <= 1'b0;
      strobe_b <= 1'b0;
      q_a      <= '0;
      q_b      <= '0;
    end else begin
      oe       <= fetch_v;
      strobe_a <= fetch_v;
      strobe_b <= fetch_v;
      q_a      <= fetch_v ? bank_rd[beat_bank(fetch_lsb, 1'b0)] : '0;
      q_b      <= fetch_v ? bank_rd[beat_bank(fetch_lsb, 1'b1)] : '0;
    end
  end

  // R4: read data appears two edges after the command register holds a read
  a_r4_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> ##2 oe);

  // R7: the bus is driven only for a read issued two edges earlier
  a_r7_oe_origin: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> $past(rd_go, 2));

  // R9: echo strobes rise only together with driven data
  a_r9_strobe_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_a || strobe_b) |-> $past(rd_go, 2));

endmodule

// File: rtl/b2s_sram.sv
module b2s_sram
  import b2s_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wd_a,
  input  logic [DW-1:0]     wd_b,
  input  logic [LANES-1:0]  lane_en_a,
  input  logic [LANES-1:0]  lane_en_b,
  output logic [DW-1:0]     rq_a,
  output logic [DW-1:0]     rq_b,
  output logic              rq_oe,
  output logic              strobe_a,
  output logic              strobe_b
);

  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic              rd_go;
  logic              wr_go;
  logic [IDX_W-1:0]  pair_idx;

  logic [1:0]            bank_we;
  logic [1:0][DW-1:0]    bank_wd;
  logic [1:0][LANES-1:0] bank_en;
  logic [1:0][DW-1:0]    bank_rd;

  b2s_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr), .addr(addr),
    .op(op), .op_addr(op_addr)
  );

  assign rd_go    = (op == OP_READ);
  assign wr_go    = (op == OP_WRITE);
  assign pair_idx = op_addr[ADDR_W-1:1];

  b2s_write_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .wr_go(wr_go), .base_lsb(op_addr[0]),
    .wd_a(wd_a), .wd_b(wd_b), .en_a(lane_en_a), .en_b(lane_en_b),
    .bank_we(bank_we), .bank_wd(bank_wd), .bank_en(bank_en)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    b2s_bank #(.IDX_W(IDX_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
      .clk(clk), .we(bank_we[b]), .wlane(bank_en[b]), .widx(pair_idx),
      .wdata(bank_wd[b]), .re(rd_go), .ridx(pair_idx), .rdata(bank_rd[b])
    );
  end

  b2s_read_pipe #(.DW(DW)) u_rpipe (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .base_lsb(op_addr[0]),
    .bank_rd(bank_rd), .q_a(rq_a), .q_b(rq_b), .oe(rq_oe),
    .strobe_a(strobe_a), .strobe_b(strobe_b)
  );

  // R8: memory is written only in the cycle after an accepted write command
  a_r8_write_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_we) |-> $past(!sel_n && !rd_wr));

  // R2: a read and a write never overlap in the command stage
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_go && (|bank_we)));

endmodule

// File: tb/b2s_sram_bench.sv
`timescale 1ns/1ps
module b2s_sram_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_n;
  logic        rd_wr;
  logic [5:0]  addr;
  logic [35:0] wd_a, wd_b;
  logic [3:0]  lane_en_a, lane_en_b;
  logic [35:0] rq_a, rq_b;
  logic        rq_oe, strobe_a, strobe_b;

  always #4 clk = ~clk;

  b2s_sram u_b2s_sram (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr), .addr(addr),
    .wd_a(wd_a), .wd_b(wd_b), .lane_en_a(lane_en_a), .lane_en_b(lane_en_b),
    .rq_a(rq_a), .rq_b(rq_b), .rq_oe(rq_oe),
    .strobe_a(strobe_a), .strobe_b(strobe_b)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  string       phase = "reset";
  logic [35:0] ref_mem [64];
  logic        xv [3];
  logic [35:0] xa [3];
  logic [35:0] xb [3];
  logic        pend_wr = 1'b0;
  logic [5:0]  pend_a = '0;

  function automatic logic [35:0] merge(input logic [35:0] old_w,
                                        input logic [35:0] new_w,
                                        input logic [3:0] en);
    logic [35:0] r = old_w;
    for (int l = 0; l < 4; l++)
      if (en[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] pat(input int a);
    return {4'h5, a[7:0], 24'hA5C300} ^ {a[5:0], 30'h0} ^ 36'(a * 36'h1_0203);
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual %h expected %h", req, phase, act, exp);
    end
  endtask

  // Drives one command for the next edge; da/db/ea/eb are late data for the
  // previous command (ignored unless that one was an accepted write).
  task automatic step(input bit s, input bit r, input logic [5:0] a,
                      input logic [35:0] da, input logic [35:0] db,
                      input logic [3:0] ea, input logic [3:0] eb);
    @(negedge clk);
    chk("R7", 36'(rq_oe), 36'(xv[2]));
    chk("R9", 36'(strobe_a), 36'(xv[2]));
    chk("R9", 36'(strobe_b), 36'(xv[2]));
    if (xv[2]) begin
      chk("R4", rq_a, xa[2]);
      chk("R3", rq_b, xb[2]);
    end else begin
      chk("R7", rq_a, 36'h0);
      chk("R7", rq_b, 36'h0);
    end
    xv[2] = xv[1]; xa[2] = xa[1]; xb[2] = xb[1];
    xv[1] = xv[0]; xa[1] = xa[0]; xb[1] = xb[0];
    sel_n = !s; rd_wr = r; addr = a;
    wd_a = da; wd_b = db; lane_en_a = ea; lane_en_b = eb;
    if (pend_wr) begin
      ref_mem[pend_a]        = merge(ref_mem[pend_a], da, ea);
      ref_mem[pend_a ^ 6'd1] = merge(ref_mem[pend_a ^ 6'd1], db, eb);
    end
    xv[0] = s && r;
    xa[0] = ref_mem[a];
    xb[0] = ref_mem[a ^ 6'd1];
    pend_wr = s && !r;
    pend_a  = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(0, $urandom_range(0, 1), 6'($urandom), {$urandom, 4'($urandom)},
           {$urandom, 4'($urandom)}, 4'hF, 4'hF);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin xv[i] = 1'b0; xa[i] = '0; xb[i] = '0; end
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    rst_n = 1'b0; sel_n = 1'b1; rd_wr = 1'b0; addr = '0;
    wd_a = '0; wd_b = '0; lane_en_a = '0; lane_en_b = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: quiet bus after reset
    chk("R10", 36'(rq_oe), 36'h0);
    chk("R10", 36'({strobe_a, strobe_b}), 36'h0);
    chk("R10", rq_a | rq_b, 36'h0);

    phase = "preload";
    for (int i = 0; i <= 32; i++)
      step(i < 32, 0, 6'(2 * i), pat(2 * i - 2), pat(2 * i - 1), 4'hF, 4'hF);

    phase = "R2 R3 R4 back-to-back reads";
    step(1, 1, 6'd5, '0, '0, 4'h0, 4'h0);
    step(1, 1, 6'd10, '1, '1, 4'hF, 4'hF);
    step(1, 1, 6'd11, '1, '1, 4'hF, 4'hF);
    step(1, 1, 6'd63, '1, '1, 4'hF, 4'hF);
    step(1, 1, 6'd0, '1, '1, 4'hF, 4'hF);
    phase = "R7 deselect after read";
    idle(4);

    phase = "R6 lane masks";
    step(1, 0, 6'd8, '0, '0, 4'h0, 4'h0);
    step(1, 0, 6'd13, 36'h1_2345_6789, 36'hF_EDCB_A987, 4'b0101, 4'b1000);
    step(1, 1, 6'd8, 36'h0_0000_0000, 36'hA_AAAA_AAAA, 4'b0000, 4'b0011);
    step(1, 1, 6'd12, '0, '0, 4'hF, 4'hF);
    idle(3);

    phase = "R5 read right after write";
    step(1, 0, 6'd21, '0, '0, 4'h0, 4'h0);
    step(1, 1, 6'd21, 36'h3_1415_9265, 36'h2_7182_8182, 4'hF, 4'hF);
    step(1, 1, 6'd20, '0, '0, 4'hF, 4'hF);
    idle(3);

    phase = "R1 R8 deselected and idle cycles";
    idle(6);
    step(0, 0, 6'd8, '1, '1, 4'hF, 4'hF);
    step(1, 1, 6'd8, 36'h9_9999_9999, 36'h9_9999_9999, 4'hF, 4'hF);
    step(1, 1, 6'd20, 36'h7_7777_7777, 36'h7_7777_7777, 4'hF, 4'hF);
    idle(3);

    phase = "random";
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), 6'($urandom),
           {$urandom, 4'($urandom)}, {$urandom, 4'($urandom)},
           4'($urandom), 4'($urandom));
    phase = "drain";
    idle(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule